// File: doc/BRIEF.md
# Sigma-delta pulse density modulator

This block is a first-order sigma-delta modulator. It turns an unsigned digital level into a single-bit stream whose density of 1s follows the level. Over a long window, the fraction of 1s in the stream equals the level divided by a programmable modulus. An analog low-pass filter after the pin can then recover a voltage proportional to that fraction. The same stream can also drive a counter as a frequency output, because the rate of 1s rises in step with the level.

The block keeps one accumulator, which is one bit wider than the modulus. On every enabled clock edge it does three things:

- It compares the accumulator with the modulus.
- It registers the result of that comparison as the output bit.
- It adds the level to the accumulator, first taking the modulus off when the comparison found the accumulator at or above the modulus.

Because the modulus is removed by an explicit compare and subtract, the modulus need not be a power of two. The level and the modulus may be changed while the block runs. A change is used from the next enabled edge, and the accumulator does not restart.

Top module: `pdm_core`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator becomes 0 and `pulse_out` becomes 0. The reset is synchronous and takes priority over `en`.
- R2: At an enabled edge where the accumulator is greater than or equal to `modulus`, `pulse_out` becomes 1 and the accumulator becomes accumulator − `modulus` + `level`.
- R3: At an enabled edge where the accumulator is below `modulus`, `pulse_out` becomes 0 and the accumulator becomes accumulator + `level`.
- R4: At an edge with `en` low and `rst` low, both the accumulator and `pulse_out` keep their values.
- R5: Legal inputs satisfy 1 ≤ `modulus` and `level` ≤ `modulus`. For legal inputs held constant after reset, skip the first enabled output. Any following N × `modulus` consecutive enabled outputs then contain exactly N × `level` ones.
- R6: When `level` is 0, `pulse_out` stays 0. When `level` equals `modulus`, `pulse_out` is 1 from the second enabled output after reset onward.
- R7: A new `level` or `modulus` is used at the next enabled edge, and the accumulator continues from its present value without restarting.
- R8: The accumulator is `W`+1 bits wide. With legal inputs it never wraps, so after each enabled edge it is at least the `level` used at that edge. This also holds at full scale, where `level` = `modulus` = 2^`W`−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable; when low, all state is held |
| level | input | W | Unsigned input value, 0 to `modulus` |
| modulus | input | W | Unsigned divisor that sets full scale, at least 1 |
| pulse_out | output | 1 | Registered pulse-density output bit |

## Verification
The assertions check the following on every cycle:

- the reset state;
- the hold when `en` is low;
- that the output follows the comparison of the accumulator with the modulus;
- that the accumulator never falls below the level just added, which is the sign of a wrap;
- that the constant-0 and constant-1 cases stay fixed once they are reached.

Some properties span a whole window or need the accumulator's trajectory followed exactly. These are the exact count of 1s over N × modulus cycles, and the continuity of the stream when the level or modulus changes mid-run. Only the bench's scenarios can show them. The bench does so with window counts for several level and modulus pairs, and with a cycle-by-cycle reference model under random level, modulus and enable patterns.

// File: rtl/pdm_core.sv
module pdm_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] level,
  input  logic [W-1:0] modulus,
  output logic         pulse_out
);

  localparam int AW = W + 1;

  logic [AW-1:0] acc_q;
  logic [AW-1:0] acc_d;
  logic [AW-1:0] lvl_x;
  logic [AW-1:0] mod_x;
  logic          fire;

  assign lvl_x = {1'b0, level};
  assign mod_x = {1'b0, modulus};
  assign fire  = (acc_q >= mod_x);
  assign acc_d = (fire ? acc_q - mod_x : acc_q) + lvl_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      pulse_out <= 1'b0;
    end else if (en) begin
      acc_q     <= acc_d;
      pulse_out <= fire;
    end
  end

  // reset has priority over enable
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0) && !pulse_out);

  assert_fire_high_R2: assert property (@(posedge clk) disable iff (rst)
    (en && acc_q >= mod_x) |=> pulse_out);

  assert_fire_low_R3: assert property (@(posedge clk) disable iff (rst)
    (en && acc_q < mod_x) |=> !pulse_out);

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc_q) && $stable(pulse_out));

  assert_zero_level_R6: assert property (@(posedge clk) disable iff (rst)
    (en && level == '0 && acc_q < mod_x) |=> !pulse_out && (acc_q < {1'b0, $past(modulus)}));

  assert_full_level_R6: assert property (@(posedge clk) disable iff (rst)
    (en && level == modulus && acc_q >= mod_x) |=> pulse_out && (acc_q >= {1'b0, $past(modulus)}));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    (en && modulus != '0 && level <= modulus) |=> (acc_q >= {1'b0, $past(level)}));

endmodule

// File: tb/pdm_core_test.sv
module pdm_core_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] level = '0;
  logic [W-1:0] modulus = 8'd1;
  logic         pulse_out;

  int total = 0;
  int bad   = 0;
  int m_acc = 0;
  bit m_out = 1'b0;

  always #2 clk = ~clk;

  pdm_core #(.W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .level(level),
    .modulus(modulus), .pulse_out(pulse_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference recurrence from R1..R4
  function automatic void model(input bit r, input bit e, input int lv, input int md);
    if (r) begin
      m_acc = 0;
      m_out = 1'b0;
    end else if (e) begin
      m_out = (m_acc >= md);
      m_acc = m_out ? m_acc - md + lv : m_acc + lv;
    end
  endfunction

  // called at a negedge: drive, pass one rising edge, return at next negedge
  task automatic step(input bit r, input bit e, input int lv, input int md, input string req);
    rst = r; en = e; level = lv[W-1:0]; modulus = md[W-1:0];
    model(r, e, lv, md);
    @(negedge clk);
    chk(pulse_out == m_out, req, int'(pulse_out), int'(m_out));
  endtask

  task automatic do_reset();
    step(1'b1, 1'b0, 0, 1, "R1");
    step(1'b1, 1'b1, 5, 9, "R1");
  endtask

  task automatic window(input int lv, input int md, input int n);
    int cnt = 0;
    do_reset();
    step(1'b0, 1'b1, lv, md, "R5");
    for (int i = 0; i < n * md; i++) begin
      step(1'b0, 1'b1, lv, md, "R5");
      cnt += int'(pulse_out);
    end
    chk(cnt == n * lv, "R5", cnt, n * lv);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    @(negedge clk);
    do_reset();
    chk(pulse_out == 1'b0, "R1", int'(pulse_out), 0);

    // R2 R3 directed: level 3 modulus 7
    for (int i = 0; i < 14; i++)
      step(1'b0, 1'b1, 3, 7, (m_acc >= 7) ? "R2" : "R3");

    // R4 hold with inputs moving
    for (int i = 0; i < 6; i++) begin
      bit prev = pulse_out;
      step(1'b0, 1'b0, i * 40, 200, "R4");
      chk(pulse_out == prev, "R4", int'(pulse_out), int'(prev));
    end
    for (int i = 0; i < 10; i++)
      step(1'b0, 1'b1, 3, 7, "R4");

    // R7 mid-run change without restart
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 5, 7, "R7");
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 2, 11, "R7");

    // R1 reset from a busy state
    do_reset();
    chk(pulse_out == 1'b0, "R1", int'(pulse_out), 0);

    // R5 windows
    window(3, 7, 3);
    window(1, 255, 2);
    window(128, 255, 2);
    window(100, 100, 1);
    window(0, 37, 2);
    window(17, 64, 2);
    for (int k = 0; k < 6; k++) begin
      int md = 1 + int'($urandom_range(254));
      int lv = int'($urandom_range(md));
      window(lv, md, 2);
    end

    // R6 constant outputs
    do_reset();
    for (int i = 0; i < 50; i++) begin
      step(1'b0, 1'b1, 0, 200, "R6");
      chk(pulse_out == 1'b0, "R6", int'(pulse_out), 0);
    end
    do_reset();
    step(1'b0, 1'b1, 90, 90, "R6");
    for (int i = 0; i < 50; i++) begin
      step(1'b0, 1'b1, 90, 90, "R6");
      chk(pulse_out == 1'b1, "R6", int'(pulse_out), 1);
    end

    // R8 full scale
    do_reset();
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 255, 255, "R8");
    for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 254, 255, "R8");

    // random mix of enable, level and modulus changes
    do_reset();
    begin
      int md = 200;
      int lv = 50;
      for (int i = 0; i < 4000; i++) begin
        bit e = ($urandom_range(3) != 0);
        if ($urandom_range(15) == 0) begin
          md = 1 + int'($urandom_range(254));
          lv = int'($urandom_range(md));
        end
        step(1'b0, e, lv, md, !e ? "R4" : (m_acc >= md) ? "R2" : "R3");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule